// File: doc/BRIEF.md
# Branch Rename Checkpoint Unit

This block keeps one snapshot of the speculative rename state for each branch still in flight. The rename logic presents the current rename map, the current free-register vector and the branch's reorder-buffer index whenever it dispatches a branch. The unit stores these three items in a free checkpoint slot and hands back that slot's number as the branch's checkpoint id. Other units carry the id along with the branch.

When the branch resolves correctly, only its own slot is released. When the branch resolved mispredicted, the unit restores state on the next cycle. It returns the saved rename map and the branch's reorder-buffer index, so the reorder buffer can cut its tail. It also returns a free vector made of the snapshot merged with every register that commits have released since the snapshot was taken. A kill mask names the mispredicted slot and every slot allocated after it. Those slots are discarded, so reservation stations and other units can squash younger work without waiting for the branch to reach the head of the reorder buffer.

Slots are ordered by allocation age, not by slot number. Slots can be released out of order, so a newer branch may sit in a lower-numbered slot than an older one.

Top module: `branch_ckpt_unit`

## Requirements
- R1: After reset no slot is live: `br_ready` is 1, `br_id` is 0 and `rs_valid` is 0.
- R2: `br_id` shows the lowest-numbered slot that is not live, and `br_ready` is 1 exactly when such a slot exists. A dispatch (`br_valid` high) while `br_ready` is low allocates nothing.
- R3: A mispredicted resolution (`res_valid`=1, `res_miss`=1) naming a live slot k raises `rs_valid` for exactly the following cycle. In that cycle `rs_id` is k, `rs_map` equals the map captured when k was allocated, and `rs_rob` equals the reorder-buffer index captured at that time.
- R4: In that restore cycle, `rs_free` equals the free vector captured at k's allocation, ORed with every `cm_free` vector presented from the allocation cycle up to and including the resolution cycle.
- R5: The same mispredict makes k and every live slot allocated after k not live. `rs_kill` (bit i is slot i) names exactly those slots, and slots allocated before k stay live.
- R6: A correct resolution (`res_miss`=0) of a live slot k releases only k; all other slots keep their state and age order.
- R7: A mispredict takes priority over a branch dispatch in the same cycle; that dispatch allocates no slot.
- R8: A resolution naming a slot that is not live has no effect: no restore, no kill, no change to any slot.
- R9: `rs_valid` is 0 in every cycle that does not follow an accepted mispredict, and `rs_kill` is all zero in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Branch dispatch request |
| br_map | input | MAP_W (32) | Rename map to capture, ARCH_N fields of PHYS_W bits |
| br_free | input | PHYS_N (16) | Free-register vector to capture, bit p set means register p is free |
| br_rob | input | ROB_W (5) | Reorder-buffer index of the branch |
| br_ready | output | 1 | A slot is available for dispatch |
| br_id | output | CKPT_W (2) | Slot that a dispatch in this cycle takes |
| res_valid | input | 1 | Branch resolution strobe |
| res_id | input | CKPT_W (2) | Checkpoint id of the resolving branch |
| res_miss | input | 1 | 1 = mispredicted, 0 = correctly predicted |
| cm_free | input | PHYS_N (16) | Registers released by commit in this cycle |
| rs_valid | output | 1 | Restore strobe |
| rs_id | output | CKPT_W (2) | Checkpoint id being restored |
| rs_map | output | MAP_W (32) | Rename map to restore |
| rs_free | output | PHYS_N (16) | Free-register vector to restore |
| rs_rob | output | ROB_W (5) | Reorder-buffer index of the mispredicted branch |
| rs_kill | output | CKPT_N (4) | Slots discarded by this restore |

## Verification
`br_ready` and `br_id` are combinational on the live set. They are sampled a short delay after inputs change, in the same cycle. Every restore output is registered and is due at the first rising edge after the resolution. It is sampled at the following falling edge, before the next stimulus is applied. A slot's liveness is not directly visible, so the bench observes it through later `br_id` values and later restores. Its reference model updates liveness, age order and accumulated commit releases at the same edge the design does.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int BCU_CKPT_N = 4;
  localparam int BCU_ARCH_N = 8;
  localparam int BCU_PHYS_N = 16;
  localparam int BCU_ROB_W  = 5;

  typedef enum logic [1:0] {
    RES_IDLE,
    RES_KEEP,
    RES_SQUASH
  } res_kind_e;
endpackage

// File: rtl/bcu_slot_pick.sv
module bcu_slot_pick #(
  parameter int N = 4,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] free_vec,
  output logic         found,
  output logic [W-1:0] pick
);
  // lowest-numbered free slot wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found = 1'b1;
        pick  = W'(i);
      end
    end
  end
endmodule

// File: rtl/bcu_age_track.sv
module bcu_age_track #(
  parameter int N = 4,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc_en,
  input  logic [W-1:0] alloc_id,
  input  logic [N-1:0] live,
  input  logic [W-1:0] query_id,
  output logic [N-1:0] younger
);
  // older_q[i][j] set: slot i was allocated before slot j
  logic [N-1:0][N-1:0] older_q, older_d;

  always_comb begin
    older_d = older_q;
    if (alloc_en) begin
      older_d[alloc_id] = '0;
      for (int i = 0; i < N; i++) begin
        older_d[i][alloc_id] = live[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older_q <= '0;
    end else if (alloc_en) begin
      older_q <= older_d;
    end
  end

  assign younger = older_q[query_id] & live;
endmodule

// File: rtl/bcu_ckpt_store.sv
module bcu_ckpt_store #(
  parameter int N      = 4,
  parameter int MAP_W  = 32,
  parameter int PHYS_N = 16,
  parameter int ROB_W  = 5,
  localparam int W = $clog2(N)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_id,
  input  logic [MAP_W-1:0]  wr_map,
  input  logic [PHYS_N-1:0] wr_free,
  input  logic [ROB_W-1:0]  wr_rob,
  input  logic [PHYS_N-1:0] cm_free,
  input  logic [N-1:0]      live,
  input  logic [W-1:0]      rd_id,
  output logic [MAP_W-1:0]  rd_map,
  output logic [PHYS_N-1:0] rd_free,
  output logic [ROB_W-1:0]  rd_rob
);
  logic [N-1:0][MAP_W-1:0]  map_all;
  logic [N-1:0][PHYS_N-1:0] free_all;
  logic [N-1:0][ROB_W-1:0]  rob_all;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic              cap_ce;
    logic              acc_ce;
    logic [MAP_W-1:0]  map_q;
    logic [PHYS_N-1:0] free_q, free_d;
    logic [ROB_W-1:0]  rob_q;

    assign cap_ce = wr_en && (wr_id == W'(g));
    assign acc_ce = live[g] || cap_ce;

    always_comb begin
      if (cap_ce) free_d = wr_free | cm_free;
      else        free_d = free_q  | cm_free;
    end

    always_ff @(posedge clk) begin
      if (cap_ce) begin
        map_q <= wr_map;
        rob_q <= wr_rob;
      end
      if (acc_ce) begin
        free_q <= free_d;
      end
    end

    assign map_all[g]  = map_q;
    assign free_all[g] = free_q;
    assign rob_all[g]  = rob_q;
  end

  assign rd_map  = map_all[rd_id];
  assign rd_free = free_all[rd_id];
  assign rd_rob  = rob_all[rd_id];
endmodule

// File: rtl/branch_ckpt_unit.sv
module branch_ckpt_unit
  import bcu_pkg::*;
#(
  parameter int CKPT_N = BCU_CKPT_N,
  parameter int ARCH_N = BCU_ARCH_N,
  parameter int PHYS_N = BCU_PHYS_N,
  parameter int ROB_W  = BCU_ROB_W,
  localparam int CKPT_W = $clog2(CKPT_N),
  localparam int PHYS_W = $clog2(PHYS_N),
  localparam int MAP_W  = ARCH_N * PHYS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [MAP_W-1:0]  br_map,
  input  logic [PHYS_N-1:0] br_free,
  input  logic [ROB_W-1:0]  br_rob,
  output logic              br_ready,
  output logic [CKPT_W-1:0] br_id,
  input  logic              res_valid,
  input  logic [CKPT_W-1:0] res_id,
  input  logic              res_miss,
  input  logic [PHYS_N-1:0] cm_free,
  output logic              rs_valid,
  output logic [CKPT_W-1:0] rs_id,
  output logic [MAP_W-1:0]  rs_map,
  output logic [PHYS_N-1:0] rs_free,
  output logic [ROB_W-1:0]  rs_rob,
  output logic [CKPT_N-1:0] rs_kill
);
  logic [CKPT_N-1:0] live_q, live_d;
  logic [CKPT_N-1:0] younger, kill_vec;
  logic              slot_found;
  logic [CKPT_W-1:0] slot_pick;
  logic              alloc_go;
  res_kind_e         kind;
  logic [MAP_W-1:0]  st_map;
  logic [PHYS_N-1:0] st_free;
  logic [ROB_W-1:0]  st_rob;

  // resolution decode: only a live slot is acted on
  always_comb begin
    kind = RES_IDLE;
    if (res_valid && live_q[res_id]) begin
      kind = res_miss ? RES_SQUASH : RES_KEEP;
    end
  end

  bcu_slot_pick #(.N(CKPT_N)) pick_i (
    .free_vec (~live_q),
    .found    (slot_found),
    .pick     (slot_pick)
  );

  assign br_ready = slot_found;
  assign br_id    = slot_pick;
  assign alloc_go = br_valid && slot_found && (kind != RES_SQUASH);

  bcu_age_track #(.N(CKPT_N)) age_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (alloc_go),
    .alloc_id (slot_pick),
    .live     (live_q),
    .query_id (res_id),
    .younger  (younger)
  );

  bcu_ckpt_store #(
    .N      (CKPT_N),
    .MAP_W  (MAP_W),
    .PHYS_N (PHYS_N),
    .ROB_W  (ROB_W)
  ) store_i (
    .clk     (clk),
    .wr_en   (alloc_go),
    .wr_id   (slot_pick),
    .wr_map  (br_map),
    .wr_free (br_free),
    .wr_rob  (br_rob),
    .cm_free (cm_free),
    .live    (live_q),
    .rd_id   (res_id),
    .rd_map  (st_map),
    .rd_free (st_free),
    .rd_rob  (st_rob)
  );

  always_comb begin
    kill_vec = '0;
    if (kind == RES_SQUASH) begin
      kill_vec = younger | (CKPT_N'(1) << res_id);
    end
  end

  always_comb begin
    live_d = live_q & ~kill_vec;
    if (kind == RES_KEEP) live_d[res_id] = 1'b0;
    if (alloc_go)         live_d[slot_pick] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= '0;
      rs_valid <= 1'b0;
      rs_kill  <= '0;
    end else begin
      live_q   <= live_d;
      rs_valid <= (kind == RES_SQUASH);
      rs_kill  <= kill_vec;
    end
  end

  // restore payload: captured only on an accepted mispredict
  always_ff @(posedge clk) begin
    if (kind == RES_SQUASH) begin
      rs_id   <= res_id;
      rs_map  <= st_map;
      rs_free <= st_free | cm_free;
      rs_rob  <= st_rob;
    end
  end
endmodule

// File: rtl/bcu_chk.sv
module bcu_chk #(
  parameter int CKPT_N = 4,
  localparam int CKPT_W = $clog2(CKPT_N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic              br_ready,
  input logic [CKPT_W-1:0] br_id,
  input logic              res_valid,
  input logic [CKPT_W-1:0] res_id,
  input logic              res_miss,
  input logic [CKPT_N-1:0] live,
  input logic              rs_valid,
  input logic [CKPT_W-1:0] rs_id,
  input logic [CKPT_N-1:0] rs_kill
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  alloc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready && !(res_valid && res_miss)) |=> live[$past(br_id)]);

  // R3
  restore_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rs_valid) |-> ($past(res_valid && res_miss) && $past(live[res_id])));

  // R5
  kill_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> rs_kill[rs_id]);

  // R5
  kill_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> ((rs_kill & live) == '0));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_miss && live[res_id]) |=> !live[$past(res_id)]);

  // R7
  miss_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss && live[res_id]) |=> ($countones(live) < $countones($past(live))));

  // R9
  quiet_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> (rs_kill == '0));
endmodule

bind branch_ckpt_unit bcu_chk #(.CKPT_N(CKPT_N)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .br_valid  (br_valid),
  .br_ready  (br_ready),
  .br_id     (br_id),
  .res_valid (res_valid),
  .res_id    (res_id),
  .res_miss  (res_miss),
  .live      (live_q),
  .rs_valid  (rs_valid),
  .rs_id     (rs_id),
  .rs_kill   (rs_kill)
);

// File: tb/branch_ckpt_unit_tb_top.sv
`timescale 1ns/1ps
module branch_ckpt_unit_tb_top;
  localparam int CKPT_N = 4;
  localparam int ARCH_N = 8;
  localparam int PHYS_N = 16;
  localparam int ROB_W  = 5;
  localparam int CKPT_W = $clog2(CKPT_N);
  localparam int PHYS_W = $clog2(PHYS_N);
  localparam int MAP_W  = ARCH_N * PHYS_W;

  logic clk;
  logic rst_n;
  logic              br_valid;
  logic [MAP_W-1:0]  br_map;
  logic [PHYS_N-1:0] br_free;
  logic [ROB_W-1:0]  br_rob;
  logic              br_ready;
  logic [CKPT_W-1:0] br_id;
  logic              res_valid;
  logic [CKPT_W-1:0] res_id;
  logic              res_miss;
  logic [PHYS_N-1:0] cm_free;
  logic              rs_valid;
  logic [CKPT_W-1:0] rs_id;
  logic [MAP_W-1:0]  rs_map;
  logic [PHYS_N-1:0] rs_free;
  logic [ROB_W-1:0]  rs_rob;
  logic [CKPT_N-1:0] rs_kill;

  branch_ckpt_unit #(.CKPT_N(CKPT_N), .ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .ROB_W(ROB_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .br_valid(br_valid), .br_map(br_map), .br_free(br_free), .br_rob(br_rob),
    .br_ready(br_ready), .br_id(br_id),
    .res_valid(res_valid), .res_id(res_id), .res_miss(res_miss),
    .cm_free(cm_free),
    .rs_valid(rs_valid), .rs_id(rs_id), .rs_map(rs_map), .rs_free(rs_free),
    .rs_rob(rs_rob), .rs_kill(rs_kill)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks;
  int errors;
  bit finished;

  // reference model
  bit [CKPT_N-1:0]   m_live;
  int                m_seq [CKPT_N];
  logic [MAP_W-1:0]  m_map [CKPT_N];
  logic [PHYS_N-1:0] m_free [CKPT_N];
  logic [ROB_W-1:0]  m_rob [CKPT_N];
  int                seq_ctr;

  function automatic int lowest_free(bit [CKPT_N-1:0] lv);
    for (int i = 0; i < CKPT_N; i++) if (!lv[i]) return i;
    return -1;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit dv, input logic [MAP_W-1:0] map, input logic [PHYS_N-1:0] fr,
                      input logic [ROB_W-1:0] rob, input bit rv, input int rid, input bit rmis,
                      input logic [PHYS_N-1:0] cf);
    int lf;
    bit mis, ok, alloc;
    bit [CKPT_N-1:0] e_kill;
    logic [CKPT_W-1:0] e_id;
    logic [MAP_W-1:0] e_map;
    logic [PHYS_N-1:0] e_free;
    logic [ROB_W-1:0] e_rob;
    br_valid = dv; br_map = map; br_free = fr; br_rob = rob;
    res_valid = rv; res_id = CKPT_W'(rid); res_miss = rmis; cm_free = cf;
    #1;
    lf = lowest_free(m_live);
    check("R2 ready", 64'(br_ready), 64'(lf >= 0));
    if (lf >= 0) check("R2 id", 64'(br_id), 64'(lf));
    mis = rv && rmis && m_live[rid];
    ok  = rv && !rmis && m_live[rid];
    alloc = dv && (lf >= 0) && !mis;
    e_kill = '0; e_id = '0; e_map = '0; e_free = '0; e_rob = '0;
    if (mis) begin
      e_id = CKPT_W'(rid); e_map = m_map[rid]; e_free = m_free[rid] | cf; e_rob = m_rob[rid];
      for (int j = 0; j < CKPT_N; j++)
        if (m_live[j] && (j == rid || m_seq[j] > m_seq[rid])) e_kill[j] = 1'b1;
    end
    for (int i = 0; i < CKPT_N; i++) if (m_live[i]) m_free[i] = m_free[i] | cf;
    m_live = m_live & ~e_kill;
    if (ok) m_live[rid] = 1'b0;
    if (alloc) begin
      m_live[lf] = 1'b1; m_seq[lf] = seq_ctr; seq_ctr++;
      m_map[lf] = map; m_free[lf] = fr | cf; m_rob[lf] = rob;
    end
    @(posedge clk);
    @(negedge clk);
    check("R9 restore strobe", 64'(rs_valid), 64'(mis));
    if (mis) begin
      check("R3 id", 64'(rs_id), 64'(e_id));
      check("R3 map", 64'(rs_map), 64'(e_map));
      check("R3 rob", 64'(rs_rob), 64'(e_rob));
      check("R4 free", 64'(rs_free), 64'(e_free));
      check("R5 kill", 64'(rs_kill), 64'(e_kill));
    end else begin
      check("R9 kill idle", 64'(rs_kill), 64'(0));
    end
  endtask

  task automatic idle();
    step(0, '0, '0, '0, 0, 0, 0, '0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    int unused_seed;
    checks = 0; errors = 0; finished = 1'b0; seq_ctr = 0; m_live = '0;
    for (int i = 0; i < CKPT_N; i++) begin
      m_seq[i] = 0; m_map[i] = '0; m_free[i] = '0; m_rob[i] = '0;
    end
    unused_seed = $urandom(32'h5eed_1234);
    br_valid = 0; br_map = '0; br_free = '0; br_rob = '0;
    res_valid = 0; res_id = '0; res_miss = 0; cm_free = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", 64'(br_ready), 64'(1));
    check("R1 id", 64'(br_id), 64'(0));
    check("R1 restore", 64'(rs_valid), 64'(0));

    // fill all slots, then dispatch while full (R2)
    step(1, 32'h0123_4567, 16'h00F0, 5'd3, 0, 0, 0, '0);
    step(1, 32'h89AB_CDEF, 16'h0F00, 5'd4, 0, 0, 0, 16'h0001);
    step(1, 32'h1111_2222, 16'hF000, 5'd5, 0, 0, 0, 16'h0002);
    step(1, 32'h3333_4444, 16'h000F, 5'd6, 0, 0, 0, 16'h0004);
    check("R2 full", 64'(br_ready), 64'(0));
    step(1, 32'hDEAD_BEEF, 16'hFFFF, 5'd7, 0, 0, 0, '0);
    // resolve a dead slot after release (R8): release slot 2 then resolve it again
    step(0, '0, '0, '0, 1, 2, 0, '0);      // R6 release slot 2 only
    check("R6 freed slot", 64'(br_id), 64'(2));
    step(0, '0, '0, '0, 1, 2, 1, 16'h0100); // R8 dead slot mispredict ignored
    check("R8 no change", 64'(br_id), 64'(2));
    // reuse slot 2 (youngest now sits in slot 2)
    step(1, 32'h5555_6666, 16'h0300, 5'd9, 0, 0, 0, 16'h0010);
    // mispredict slot 1 with a dispatch in the same cycle (R7): kills 1,3,2
    step(1, 32'h7777_8888, 16'h0000, 5'd10, 1, 1, 1, 16'h0020);
    check("R7 dispatch dropped", 64'(br_id), 64'(1));
    // oldest slot 0 still live, mispredict on it kills it alone
    step(0, '0, '0, '0, 1, 0, 1, 16'h8000);
    check("R5 all free", 64'(br_id), 64'(0));
    idle();

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      bit dv, rv, rmis;
      int rid;
      logic [PHYS_N-1:0] cf;
      dv   = ($urandom % 100) < 55;
      rv   = ($urandom % 100) < 35;
      rmis = ($urandom % 100) < 40;
      rid  = int'($urandom % CKPT_N);
      cf   = PHYS_N'($urandom & $urandom & $urandom);
      step(dv, MAP_W'($urandom), PHYS_N'($urandom), ROB_W'($urandom), rv, rid, rmis, cf);
    end
    finish_run();
  end
endmodule